// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is the counting core of a real-time clock. A periodic tick enable comes from a prescaler outside the block. An internal sub-second divider turns every `SUB_TICKS` of those ticks into one second step. Each second step moves a packed BCD calendar forward: seconds, minutes, hours, day of month, weekday, month and a two-digit year. The day of month follows the length of the current month, and February gains its 29th day in years whose BCD value is a multiple of four. Hours can be counted either as a 24-hour value or as a 12-hour value with an afternoon flag.

A host reaches the block through a simple register port. Writes are synchronous, and reads are combinational on a separate address. To set the clock, the host raises the halt bit in the control register, writes the seven time fields, then clears the halt bit. The sub-second divider is held at zero while the clock is halted, so the first step after release comes exactly one second later. The seconds register also carries a sticky flag that reports that the held time cannot be trusted. Power-on reset and a software reset command set this flag. Only a host write clears it.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the registers read as follows: address 0x2 (seconds) 0x80, 0x3 (minutes) 0x00, 0x4 (hours) 0x00, 0x5 (day) 0x01, 0x6 (weekday) 0x00, 0x7 (month) 0x01, 0x8 (year) 0x00 and 0x0 (control) 0x00.
- R2: While not halted, the seconds field takes one BCD step on the `SUB_TICKS`-th cycle that has `tick_in` high. With no step and no write, no field changes.
- R3: In 24-hour mode, seconds 59 wraps to 00 and steps minutes. Minutes 59 wraps to 00 and steps hours. Hours 23 wraps to 00 and steps both the day and the weekday.
- R4: The weekday (3-bit binary, address 0x6) steps from 6 to 0.
- R5: The day of month wraps to 01 and steps the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. February wraps after day 28, or after day 29 when the BCD year is divisible by 4 (year 00 included).
- R6: Month 12 wraps to 01 and steps the year. Year 99 wraps to 00, and BCD digit carries apply (19 steps to 20).
- R7: While control bit 5 (halt) is 1, no time field changes and the sub-second divider is held at zero. After halt is cleared, the next step comes on the `SUB_TICKS`-th tick.
- R8: Bit 7 of the seconds register is the time-invalid flag. It is set by reset, and counting never clears it. A seconds write with bit 7 = 0 clears it, and a seconds write with bit 7 = 1 leaves it unchanged.
- R9: With control bit 2 set (12-hour mode), the hours register holds a PM flag in bit 5 and BCD 01 to 12 in bits 4:0. The steps are: 11 AM (0x11) to 12 PM (0x32), 12 PM to 01 PM (0x21), 11 PM (0x31) to 12 AM (0x12) with a day step, and 12 AM to 01 AM (0x01).
- R10: Writing exactly 0x58 to the control register returns every register to its R1 value, including the flag and the control bits, and clears the sub-second divider.
- R11: When a field write and a second step fall on the same clock edge, the written field takes the write data. Every other field takes its stepped value as if the write had not happened.
- R12: Writes store only the field bits: seconds 7, minutes 7, hours 6, day 6, weekday 3, month 5 and year 8, with control bits 5 and 2 only. All other bits read 0. Addresses other than 0x0 and 0x2 to 0x8 read 0x00, and writes to them have no effect. `rd_data` follows `rd_addr` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | 1 | Sub-second tick enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |

## Verification
A host write to a time field can land on the same edge as the second step that would carry into that field. The bench provokes this by running the divider to one tick short of a second, then raising `tick_in` and `wr_en` together on the next cycle. In one case minutes are written while seconds roll from 59. In another, seconds are written while they would have stepped on their own. The bench then checks that the written field holds exactly the written value and that its neighbours hold their stepped values.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  // register map; the time block sits at consecutive addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'h3;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'h4;
  localparam logic [ADDR_W-1:0] A_MDAY = 4'h5;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'h6;
  localparam logic [ADDR_W-1:0] A_MON  = 4'h7;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'h8;

  localparam int HALT_BIT = 5;
  localparam int H12_BIT  = 2;
  localparam logic [DATA_W-1:0] RESET_CODE = 8'h58;

  typedef struct packed {
    logic [7:0] yr;
    logic [4:0] mon;
    logic [2:0] wday;
    logic [5:0] mday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{yr: 8'h00, mon: 5'h01, wday: 3'd0,
                                 mday: 6'h01, hour: 6'h00, min: 7'h00,
                                 sec: 7'h00};

  // one BCD step of a two-digit value, no wrap
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int SUB_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic halt,
  input  logic tick_in,
  output logic sec_pulse
);

  localparam int CNT_W = (SUB_TICKS > 2) ? $clog2(SUB_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SUB_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sec_pulse = tick_in && !halt && (cnt_q == LAST);
    cnt_d     = cnt_q;
    if (clear || halt)  cnt_d = '0;
    else if (sec_pulse) cnt_d = '0;
    else if (tick_in)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a halted clock keeps the divider at zero
  p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic [4:0] mon,
  input  logic [7:0] yr,
  output logic [5:0] last_day
);

  always_comb begin
    case (mon)
      5'h02:                      last_day = bcd_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  cal_t cur,
  input  logic adv,
  input  logic h12,
  output cal_t nxt
);

  logic [5:0] last_day;
  logic [7:0] inc_sec, inc_min, inc_hr, inc_h12, inc_day, inc_mon, inc_yr;
  logic       c_min, c_hour, c_day, c_mon, c_yr, hr_wrap;
  logic [5:0] hr_next;
  logic       unused_bits;

  rtc_month_len u_len (
    .mon      (cur.mon),
    .yr       (cur.yr),
    .last_day (last_day)
  );

  assign unused_bits = ^{inc_sec[7], inc_min[7], inc_hr[7:6], inc_h12[7:5],
                         inc_day[7:6], inc_mon[7:5]};

  always_comb begin
    inc_sec = bcd_step({1'b0, cur.sec});
    inc_min = bcd_step({1'b0, cur.min});
    inc_hr  = bcd_step({2'b0, cur.hour});
    inc_h12 = bcd_step({3'b0, cur.hour[4:0]});
    inc_day = bcd_step({2'b0, cur.mday});
    inc_mon = bcd_step({3'b0, cur.mon});
    inc_yr  = bcd_step(cur.yr);

    // hour successor and whether it rolls into a new day
    if (h12) begin
      if (cur.hour[4:0] == 5'h11) begin
        hr_next = {~cur.hour[5], 5'h12};
        hr_wrap = cur.hour[5];
      end else if (cur.hour[4:0] >= 5'h12) begin
        hr_next = {cur.hour[5], 5'h01};
        hr_wrap = 1'b0;
      end else begin
        hr_next = {cur.hour[5], inc_h12[4:0]};
        hr_wrap = 1'b0;
      end
    end else if (cur.hour >= 6'h23) begin
      hr_next = 6'h00;
      hr_wrap = 1'b1;
    end else begin
      hr_next = inc_hr[5:0];
      hr_wrap = 1'b0;
    end

    c_min  = adv && (cur.sec >= 7'h59);
    c_hour = c_min && (cur.min >= 7'h59);
    c_day  = c_hour && hr_wrap;
    c_mon  = c_day && (cur.mday >= last_day);
    c_yr   = c_mon && (cur.mon >= 5'h12);

    nxt = cur;
    if (adv)    nxt.sec  = c_min ? 7'h00 : inc_sec[6:0];
    if (c_min)  nxt.min  = c_hour ? 7'h00 : inc_min[6:0];
    if (c_hour) nxt.hour = hr_next;
    if (c_day) begin
      nxt.mday = c_mon ? 6'h01 : inc_day[5:0];
      nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
    end
    if (c_mon)  nxt.mon  = c_yr ? 5'h01 : inc_mon[4:0];
    if (c_yr)   nxt.yr   = (cur.yr >= 8'h99) ? 8'h00 : inc_yr;
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int SUB_TICKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  cal_t cal_q, cal_d, cal_step;
  logic osf_q, osf_d;
  logic halt_q, halt_d;
  logic h12_q, h12_d;
  logic soft_rst, sec_pulse;

  assign soft_rst = wr_en && (wr_addr == A_CTRL) && (wr_data == RESET_CODE);

  rtc_subsec_div #(.SUB_TICKS(SUB_TICKS)) u_div (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clear     (soft_rst),
    .halt      (halt_q),
    .tick_in   (tick_in),
    .sec_pulse (sec_pulse)
  );

  rtc_time_chain u_chain (
    .cur (cal_q),
    .adv (sec_pulse),
    .h12 (h12_q),
    .nxt (cal_step)
  );

  // next state: software reset, then host write per field, then stepping
  always_comb begin
    cal_d  = cal_step;
    osf_d  = osf_q;
    halt_d = halt_q;
    h12_d  = h12_q;
    if (soft_rst) begin
      cal_d  = CAL_RESET;
      osf_d  = 1'b1;
      halt_d = 1'b0;
      h12_d  = 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          halt_d = wr_data[HALT_BIT];
          h12_d  = wr_data[H12_BIT];
        end
        A_SEC: begin
          cal_d.sec = wr_data[6:0];
          osf_d     = osf_q & wr_data[7];
        end
        A_MIN:   cal_d.min  = wr_data[6:0];
        A_HOUR:  cal_d.hour = wr_data[5:0];
        A_MDAY:  cal_d.mday = wr_data[5:0];
        A_WDAY:  cal_d.wday = wr_data[2:0];
        A_MON:   cal_d.mon  = wr_data[4:0];
        A_YEAR:  cal_d.yr   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cal_q  <= CAL_RESET;
      osf_q  <= 1'b1;
      halt_q <= 1'b0;
      h12_q  <= 1'b0;
    end else begin
      cal_q  <= cal_d;
      osf_q  <= osf_d;
      halt_q <= halt_d;
      h12_q  <= h12_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {2'b00, halt_q, 2'b00, h12_q, 2'b00};
      A_SEC:   rd_data = {osf_q, cal_q.sec};
      A_MIN:   rd_data = {1'b0, cal_q.min};
      A_HOUR:  rd_data = {2'b00, cal_q.hour};
      A_MDAY:  rd_data = {2'b00, cal_q.mday};
      A_WDAY:  rd_data = {5'b00000, cal_q.wday};
      A_MON:   rd_data = {3'b000, cal_q.mon};
      A_YEAR:  rd_data = cal_q.yr;
      default: rd_data = '0;
    endcase
  end

  // R7: halted and untouched means frozen
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (halt_q && !wr_en) |=> $stable(cal_q));

  // R2: no step and no write leaves the calendar alone
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!sec_pulse && !wr_en) |=> $stable(cal_q));

  // R2: a step below 59 is a single BCD increment of seconds
  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sec_pulse && !wr_en && (cal_q.sec < 7'h59))
      |=> ({1'b0, cal_q.sec} == bcd_step({1'b0, $past(cal_q.sec)})));

  // R8: the invalid flag only drops through a seconds write with bit 7 low
  p_osf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (osf_q && !(wr_en && (wr_addr == A_SEC) && !wr_data[7])) |=> osf_q);

  // R4: weekday wraps from 6 to 0 at the day boundary
  p_wday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sec_pulse && !wr_en && !h12_q && (cal_q.sec == 7'h59) &&
     (cal_q.min == 7'h59) && (cal_q.hour == 6'h23) && (cal_q.wday == 3'd6))
      |=> (cal_q.wday == 3'd0));

endmodule

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;

  localparam int T = 32;
  localparam int NV = 21;

  logic       clk, rst_n, tick_in, wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int         n_chk, n_bad;
  bit         done;

  rtc_calendar_core #(.SUB_TICKS(T)) uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       h12;
    logic [7:0] s, m, h, d, w, mo, y;
    logic [7:0] es, em, eh, ed, ew, emo, ey;
    logic [3:0] rq;
  } vec_t;

  // load time, run exactly one second, expect the stepped time
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h05,8'h00,8'h00,8'h15,8'h03,8'h06,8'h24, 8'h06,8'h00,8'h00,8'h15,8'h03,8'h06,8'h24, 4'd2},
    '{1'b0, 8'h59,8'h59,8'h10,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h11,8'h15,8'h03,8'h06,8'h24, 4'd3},
    '{1'b0, 8'h59,8'h59,8'h09,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h10,8'h15,8'h03,8'h06,8'h24, 4'd3},
    '{1'b0, 8'h59,8'h59,8'h23,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h00,8'h16,8'h04,8'h06,8'h24, 4'd3},
    '{1'b0, 8'h59,8'h59,8'h23,8'h10,8'h06,8'h06,8'h24, 8'h00,8'h00,8'h00,8'h11,8'h00,8'h06,8'h24, 4'd4},
    '{1'b0, 8'h59,8'h59,8'h23,8'h31,8'h02,8'h01,8'h23, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h02,8'h23, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h30,8'h02,8'h04,8'h23, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h05,8'h23, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'h02,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h03,8'h23, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'h02,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h29,8'h03,8'h02,8'h24, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'h02,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h29,8'h03,8'h02,8'h00, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h29,8'h02,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h03,8'h00, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h30,8'h02,8'h10,8'h23, 8'h00,8'h00,8'h00,8'h31,8'h03,8'h10,8'h23, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h30,8'h02,8'h11,8'h23, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h12,8'h23, 4'd5},
    '{1'b0, 8'h59,8'h59,8'h23,8'h31,8'h05,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h06,8'h01,8'h00, 4'd6},
    '{1'b0, 8'h59,8'h59,8'h23,8'h31,8'h05,8'h12,8'h19, 8'h00,8'h00,8'h00,8'h01,8'h06,8'h01,8'h20, 4'd6},
    '{1'b1, 8'h59,8'h59,8'h11,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h32,8'h15,8'h03,8'h06,8'h24, 4'd9},
    '{1'b1, 8'h59,8'h59,8'h32,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h21,8'h15,8'h03,8'h06,8'h24, 4'd9},
    '{1'b1, 8'h59,8'h59,8'h31,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h12,8'h16,8'h04,8'h06,8'h24, 4'd9},
    '{1'b1, 8'h59,8'h59,8'h12,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h01,8'h15,8'h03,8'h06,8'h24, 4'd9},
    '{1'b1, 8'h59,8'h59,8'h09,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h10,8'h15,8'h03,8'h06,8'h24, 4'd9},
    '{1'b1, 8'h59,8'h59,8'h29,8'h15,8'h03,8'h06,8'h24, 8'h00,8'h00,8'h30,8'h15,8'h03,8'h06,8'h24, 4'd9}
  };

  function automatic string rq_name(input logic [3:0] k);
    case (k)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  // one tick cycle that carries a write on the same edge
  task automatic tick_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_in = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    tick_in = 1'b0; wr_en = 1'b0;
  endtask

  task automatic chk(input string rq, input logic [3:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s addr 0x%0h: got 0x%02h expected 0x%02h", rq, a, rd_data, exp);
    end
  endtask

  task automatic chk_reset_state(input string rq);
    chk(rq, 4'h0, 8'h00);
    chk(rq, 4'h2, 8'h80);
    chk(rq, 4'h3, 8'h00);
    chk(rq, 4'h4, 8'h00);
    chk(rq, 4'h5, 8'h01);
    chk(rq, 4'h6, 8'h00);
    chk(rq, 4'h7, 8'h01);
    chk(rq, 4'h8, 8'h00);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; tick_in = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    chk_reset_state("R1");

    // R8: flag survives counting and a write of 1; a write of 0 clears it
    ticks(T);
    chk("R8", 4'h2, 8'h81);
    wr(4'h2, 8'h85);
    chk("R8", 4'h2, 8'h85);
    wr(4'h2, 8'h05);
    chk("R8", 4'h2, 8'h05);
    ticks(T);
    chk("R8", 4'h2, 8'h06);

    // vector table: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      wr(4'h0, 8'h20 | (VECS[i].h12 ? 8'h04 : 8'h00));
      wr(4'h2, VECS[i].s);
      wr(4'h3, VECS[i].m);
      wr(4'h4, VECS[i].h);
      wr(4'h5, VECS[i].d);
      wr(4'h6, VECS[i].w);
      wr(4'h7, VECS[i].mo);
      wr(4'h8, VECS[i].y);
      wr(4'h0, VECS[i].h12 ? 8'h04 : 8'h00);
      ticks(T);
      chk(rq_name(VECS[i].rq), 4'h2, VECS[i].es);
      chk(rq_name(VECS[i].rq), 4'h3, VECS[i].em);
      chk(rq_name(VECS[i].rq), 4'h4, VECS[i].eh);
      chk(rq_name(VECS[i].rq), 4'h5, VECS[i].ed);
      chk(rq_name(VECS[i].rq), 4'h6, VECS[i].ew);
      chk(rq_name(VECS[i].rq), 4'h7, VECS[i].emo);
      chk(rq_name(VECS[i].rq), 4'h8, VECS[i].ey);
    end

    // R7: halt freezes and restarts the divider from zero
    wr(4'h0, 8'h20);
    wr(4'h2, 8'h10);
    wr(4'h3, 8'h00);
    wr(4'h4, 8'h00);
    wr(4'h0, 8'h00);
    ticks(T / 2);
    wr(4'h0, 8'h20);
    ticks(3 * T);
    chk("R7", 4'h2, 8'h10);
    chk("R7", 4'h3, 8'h00);
    wr(4'h0, 8'h00);
    ticks(T - 1);
    chk("R7", 4'h2, 8'h10);
    ticks(1);
    chk("R7", 4'h2, 8'h11);

    // R11: write and step on one edge
    wr(4'h0, 8'h20);
    wr(4'h2, 8'h59);
    wr(4'h3, 8'h10);
    wr(4'h4, 8'h05);
    wr(4'h0, 8'h00);
    ticks(T - 1);
    tick_wr(4'h3, 8'h42);
    chk("R11", 4'h2, 8'h00);
    chk("R11", 4'h3, 8'h42);
    chk("R11", 4'h4, 8'h05);
    wr(4'h2, 8'h20);
    ticks(T - 1);
    tick_wr(4'h2, 8'h30);
    chk("R11", 4'h2, 8'h30);
    chk("R11", 4'h3, 8'h42);

    // R12: unmapped addresses and field masking
    wr(4'h0, 8'h20);
    wr(4'h1, 8'hFF);
    wr(4'h9, 8'hFF);
    wr(4'hF, 8'hAA);
    chk("R12", 4'h1, 8'h00);
    chk("R12", 4'h9, 8'h00);
    chk("R12", 4'hF, 8'h00);
    chk("R12", 4'h2, 8'h30);
    chk("R12", 4'h3, 8'h42);
    wr(4'h3, 8'hFF);
    chk("R12", 4'h3, 8'h7F);
    wr(4'h4, 8'hFF);
    chk("R12", 4'h4, 8'h3F);
    wr(4'h5, 8'hFF);
    chk("R12", 4'h5, 8'h3F);
    wr(4'h6, 8'hFF);
    chk("R12", 4'h6, 8'h07);
    wr(4'h7, 8'hFF);
    chk("R12", 4'h7, 8'h1F);
    wr(4'h0, 8'hFF);
    chk("R12", 4'h0, 8'h24);

    // R10: software reset code restores everything, divider included
    wr(4'h0, 8'h00);
    wr(4'h2, 8'h20);
    ticks(T / 2);
    wr(4'h0, 8'h58);
    chk_reset_state("R10");
    ticks(T - 1);
    chk("R10", 4'h2, 8'h80);
    ticks(1);
    chk("R10", 4'h2, 8'h81);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule